// File: doc/BRIEF.md
# NAND Flash Strobe Interface Controller

This block sits on a simple request/ready host bus and drives the pins of a raw 8-bit NAND flash device. Software steers the flash control lines through a mode register: the chip-enable bit, a two-bit chip-select field choosing one of up to four CE# outputs, the command-latch and address-latch enables, and a write-mode bit. Every access to the data register then turns into one timed flash bus cycle. A write (with write mode on) drives the low byte onto the bus under a WE# pulse. A read pulses RE# and returns the byte sampled at the end of the pulse.

Pulse width and post-pulse hold come from one packed timing register. The host access is held off with `hc_ready` until the whole flash cycle, hold included, has finished. A status register reports the synchronised ready/busy pin. A reset register starts a soft reset that returns the mode and timing registers to their defaults. Its bit reads as 1 until the reset has run its course.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After hardware reset all CE# outputs, WE# and RE# are high, CLE, ALE, `fl_dq_oe` and `hc_ready` are low, the mode register reads 0x00 and the timing register reads 0x11.
- R2: The mode register sits at byte offset 0x04. When its bit 4 is 1, the CE# output selected by bits 3:2 is driven low and all others stay high. When bit 4 is 0, all CE# outputs are high. The register reads back as written.
- R3: `fl_cle` equals mode bit 0 and `fl_ale` equals mode bit 1 from the cycle after the register write.
- R4: A write to the data register (offset 0x00) with mode bit 7 set drives WE# low for exactly SPW+1 cycles. During the pulse, `fl_dq_oe` is high and `fl_dq_o` carries `hc_wdata[7:0]`. RE# stays high.
- R5: After the strobe ends, `fl_dq_oe` and `fl_dq_o` stay unchanged for HOLD cycles. The access then completes with a one-cycle `hc_ready` pulse, SPW+HOLD+2 cycles after the request was accepted.
- R6: A read of the data register drives RE# low for SPW+1 cycles and then waits HOLD cycles. It returns on `hc_rdata` the `fl_dq_i` byte sampled on the last strobe cycle, with the upper bits zero.
- R7: A write to the data register while mode bit 7 is 0 produces no strobe and never enables the data drivers. It completes with `hc_ready` one cycle after acceptance.
- R8: The timing register (offset 0x14) holds HOLD in bits 7:4 and SPW in bits 3:0. A field written as 0 is stored as 1, and the register reads back the stored values.
- R9: Status register (offset 0x08) bit 7 reads 1 while `fl_rb_n` is low. The value passes through a SYNC_STAGES-flop synchroniser, and the other bits read 0.
- R10: Writing 1 to bit 0 of the reset register (offset 0x18) sets the mode register to 0x00 and the timing register to 0x11. That bit then reads 1 for RST_CYCLES cycles and clears itself. Data-register accesses wait until it clears. Writing 0 to the bit has no effect.
- R11: Register accesses other than the data register complete with `hc_ready` one cycle after acceptance. The interrupt status (0x0C) and interrupt mask (0x10) offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hc_req | input | 1 | Host request, held until `hc_ready` |
| hc_we | input | 1 | Host write (1) or read (0) |
| hc_addr | input | ADDR_W | Host byte address |
| hc_wdata | input | DATA_W | Host write data |
| hc_rdata | output | DATA_W | Host read data, valid with `hc_ready` |
| hc_ready | output | 1 | One-cycle completion pulse |
| fl_ce_n | output | NUM_CS | Flash chip enables, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_re_n | output | 1 | Read strobe, active low |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_rb_n | input | 1 | Flash ready/busy, low when busy |

## Verification
Writes are swept over all 256 timing register values, including the zero fields that must be raised to 1. Each write measures the pulse length, the hold length and the total latency, so an off-by-one in either counter, or a swapped field, shows up at once. Reads are swept over every SPW value with a different byte on the flash bus each time, which separates correct sampling from stale data. Every chip-select, chip-enable and latch-enable combination is applied and read back. The soft reset is tested for its register defaults, for how long its bit reads 1, and for the stall it imposes on a data access.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
   // register indices (byte offset >> 2)
   localparam int REG_DATA  = 0;
   localparam int REG_MODE  = 1;
   localparam int REG_STAT  = 2;
   localparam int REG_ISTAT = 3;
   localparam int REG_IMASK = 4;
   localparam int REG_TIME  = 5;
   localparam int REG_RST   = 6;

   // mode register bit positions
   localparam int MB_CLE  = 0;
   localparam int MB_ALE  = 1;
   localparam int MB_CSLO = 2;
   localparam int MB_CE   = 4;
   localparam int MB_WEN  = 7;

   localparam int TF_W = 4;   // width of each timing field
   localparam int CS_FIELD_W = 2;
   localparam int STAT_BUSY = 7;

   typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_HOLD, SQ_ACK} seq_state_t;

   function automatic logic [TF_W-1:0] fix_field(input logic [TF_W-1:0] v);
      return (v == '0) ? TF_W'(1) : v;
   endfunction
endpackage

// File: rtl/nsc_regs.sv
module nsc_regs
   import nsc_pkg::*;
#(
   parameter int RST_CYCLES = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_mode,
   input  logic            wr_time,
   input  logic            wr_reset,
   input  logic [7:0]      wbyte,
   output logic [7:0]      mode,
   output logic [TF_W-1:0] spw,
   output logic [TF_W-1:0] hold,
   output logic            rst_busy
);
   localparam int RCNT_W = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 2) begin : g_bad_rst
      $error("RST_CYCLES must be at least 2");
   end

   logic [RCNT_W-1:0] rcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         spw    <= TF_W'(1);
         hold   <= TF_W'(1);
         rcnt_q <= '0;
      end else if (wr_reset && wbyte[0]) begin
         mode   <= '0;
         spw    <= TF_W'(1);
         hold   <= TF_W'(1);
         rcnt_q <= RCNT_W'(RST_CYCLES);
      end else begin
         if (rcnt_q != '0) rcnt_q <= rcnt_q - RCNT_W'(1);
         if (wr_mode) mode <= wbyte;
         if (wr_time) begin
            hold <= fix_field(wbyte[7:4]);
            spw  <= fix_field(wbyte[3:0]);
         end
      end
   end

   assign rst_busy = (rcnt_q != '0);

   // R8
   timing_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spw != '0) && (hold != '0));

   // R10
   reset_bit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rcnt_q == RCNT_W'(1)) |=> !rst_busy);
endmodule

// File: rtl/nsc_pins.sv
module nsc_pins
   import nsc_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce_bit,
   input  logic [CS_FIELD_W-1:0] cs_sel,
   input  logic                  cle_bit,
   input  logic                  ale_bit,
   input  logic                  rb_n,
   output logic [NUM_CS-1:0]     ce_n,
   output logic                  cle,
   output logic                  ale,
   output logic                  busy
);
   if (NUM_CS < 1 || NUM_CS > (1 << CS_FIELD_W)) begin : g_bad_cs
      $error("NUM_CS must be between 1 and 4");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
      assign ce_n[i] = !(ce_bit && (cs_sel == CS_FIELD_W'(i)));
   end

   assign cle = cle_bit;
   assign ale = ale_bit;

   logic [SYNC_STAGES-1:0] rb_sync_q;
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rb_sync_q <= '1;
         else        rb_sync_q <= rb_n;
      end
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rb_sync_q <= '1;
         else        rb_sync_q <= {rb_sync_q[SYNC_STAGES-2:0], rb_n};
      end
   end
   assign busy = !rb_sync_q[SYNC_STAGES-1];

   // R2
   ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ce_n));
   // R2
   ce_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_bit |-> (&ce_n));
endmodule

// File: rtl/nsc_seq.sv
module nsc_seq
   import nsc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            we,
   input  logic            is_data,
   input  logic            wmode,
   input  logic [7:0]      wbyte,
   input  logic [TF_W-1:0] spw,
   input  logic [TF_W-1:0] hold,
   input  logic            rst_busy,
   output logic            ack,
   output logic            commit,
   output logic            rd_load,
   output logic            we_n,
   output logic            re_n,
   output logic [7:0]      dq_o,
   output logic            dq_oe
);
   seq_state_t      st_q;
   logic [TF_W-1:0] cnt_q;

   assign commit  = (st_q == SQ_IDLE) && req && !is_data;
   assign rd_load = (st_q == SQ_STROBE) && (cnt_q == '0) && !re_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
         we_n  <= 1'b1;
         re_n  <= 1'b1;
         dq_o  <= '0;
         dq_oe <= 1'b0;
         ack   <= 1'b0;
      end else begin
         ack <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (req) begin
                  if (!is_data) begin
                     ack  <= 1'b1;
                     st_q <= SQ_ACK;
                  end else if (!rst_busy) begin
                     if (we && !wmode) begin
                        ack  <= 1'b1;
                        st_q <= SQ_ACK;
                     end else begin
                        st_q  <= SQ_STROBE;
                        cnt_q <= spw;
                        if (we) begin
                           we_n  <= 1'b0;
                           dq_oe <= 1'b1;
                           dq_o  <= wbyte;
                        end else begin
                           re_n <= 1'b0;
                        end
                     end
                  end
               end
            end
            SQ_STROBE: begin
               if (cnt_q == '0) begin
                  we_n  <= 1'b1;
                  re_n  <= 1'b1;
                  st_q  <= SQ_HOLD;
                  cnt_q <= hold - TF_W'(1);
               end else begin
                  cnt_q <= cnt_q - TF_W'(1);
               end
            end
            SQ_HOLD: begin
               if (cnt_q == '0) begin
                  dq_oe <= 1'b0;
                  ack   <= 1'b1;
                  st_q  <= SQ_ACK;
               end else begin
                  cnt_q <= cnt_q - TF_W'(1);
               end
            end
            SQ_ACK:  st_q <= SQ_IDLE;
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   // strobe width checker state
   logic           strobe_n;
   logic [TF_W:0]  width_q;
   assign strobe_n = we_n & re_n;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        width_q <= '0;
      else if (!strobe_n) width_q <= width_q + (TF_W+1)'(1);
      else               width_q <= '0;
   end

   // R4
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_n) |-> (width_q == ({1'b0, spw} + (TF_W+1)'(1))));
   // R4
   no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n));
   // R4
   we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> dq_oe);
   // R5
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_o));
   // R5
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   // R7
   we_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> wmode);
endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
   import nsc_pkg::*;
#(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 32,
   parameter int NUM_CS      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYCLES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hc_req,
   input  logic              hc_we,
   input  logic [ADDR_W-1:0] hc_addr,
   input  logic [DATA_W-1:0] hc_wdata,
   output logic [DATA_W-1:0] hc_rdata,
   output logic              hc_ready,
   output logic [NUM_CS-1:0] fl_ce_n,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_we_n,
   output logic              fl_re_n,
   output logic [7:0]        fl_dq_o,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_i,
   input  logic              fl_rb_n
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must be at least 5");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end

   logic [IDX_W-1:0] idx;
   logic             is_data, commit, rd_load;
   logic             wr_mode, wr_time, wr_reset;
   logic [7:0]       mode;
   logic [TF_W-1:0]  spw, hold;
   logic             rst_busy, busy;
   logic [7:0]       rd_mux;
   logic             unused_bits;

   assign idx         = hc_addr[ADDR_W-1:2];
   assign unused_bits = ^{hc_addr[1:0], hc_wdata[DATA_W-1:8]};
   assign is_data     = (idx == IDX_W'(REG_DATA));
   assign wr_mode     = commit && hc_we && (idx == IDX_W'(REG_MODE));
   assign wr_time     = commit && hc_we && (idx == IDX_W'(REG_TIME));
   assign wr_reset    = commit && hc_we && (idx == IDX_W'(REG_RST));

   nsc_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_mode  (wr_mode),
      .wr_time  (wr_time),
      .wr_reset (wr_reset),
      .wbyte    (hc_wdata[7:0]),
      .mode     (mode),
      .spw      (spw),
      .hold     (hold),
      .rst_busy (rst_busy)
   );

   nsc_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (hc_req),
      .we       (hc_we),
      .is_data  (is_data),
      .wmode    (mode[MB_WEN]),
      .wbyte    (hc_wdata[7:0]),
      .spw      (spw),
      .hold     (hold),
      .rst_busy (rst_busy),
      .ack      (hc_ready),
      .commit   (commit),
      .rd_load  (rd_load),
      .we_n     (fl_we_n),
      .re_n     (fl_re_n),
      .dq_o     (fl_dq_o),
      .dq_oe    (fl_dq_oe)
   );

   nsc_pins #(.NUM_CS(NUM_CS), .SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_bit  (mode[MB_CE]),
      .cs_sel  (mode[MB_CSLO +: CS_FIELD_W]),
      .cle_bit (mode[MB_CLE]),
      .ale_bit (mode[MB_ALE]),
      .rb_n    (fl_rb_n),
      .ce_n    (fl_ce_n),
      .cle     (fl_cle),
      .ale     (fl_ale),
      .busy    (busy)
   );

   always_comb begin
      rd_mux = '0;
      case (idx)
         IDX_W'(REG_MODE): rd_mux = mode;
         IDX_W'(REG_STAT): rd_mux[STAT_BUSY] = busy;
         IDX_W'(REG_TIME): rd_mux = {hold, spw};
         IDX_W'(REG_RST):  rd_mux[0] = rst_busy;
         default:          rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hc_rdata <= '0;
      else if (rd_load)          hc_rdata <= DATA_W'(fl_dq_i);
      else if (commit && !hc_we) hc_rdata <= DATA_W'(rd_mux);
   end

   // R11
   reg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> hc_ready);
endmodule

// File: tb/tb_nand_strobe_ctrl.sv
module tb_nand_strobe_ctrl;
   localparam int RSTC = 3;
   localparam int IX_DATA = 0, IX_MODE = 1, IX_STAT = 2, IX_ISTAT = 3,
                  IX_IMASK = 4, IX_TIME = 5, IX_RST = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hc_req = 1'b0, hc_we = 1'b0;
   logic [4:0]  hc_addr = '0;
   logic [31:0] hc_wdata = '0;
   logic [31:0] hc_rdata;
   logic        hc_ready;
   logic [3:0]  fl_ce_n;
   logic        fl_cle, fl_ale, fl_we_n, fl_re_n, fl_dq_oe;
   logic [7:0]  fl_dq_o;
   logic [7:0]  fl_dq_i = '0;
   logic        fl_rb_n = 1'b1;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   nand_strobe_ctrl #(.ADDR_W(5), .DATA_W(32), .NUM_CS(4), .SYNC_STAGES(2),
                      .RST_CYCLES(RSTC)) dut (
      .clk(clk), .rst_n(rst_n), .hc_req(hc_req), .hc_we(hc_we),
      .hc_addr(hc_addr), .hc_wdata(hc_wdata), .hc_rdata(hc_rdata),
      .hc_ready(hc_ready), .fl_ce_n(fl_ce_n), .fl_cle(fl_cle),
      .fl_ale(fl_ale), .fl_we_n(fl_we_n), .fl_re_n(fl_re_n),
      .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
      .fl_rb_n(fl_rb_n)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic reg_acc(input bit wr, input int ix, input logic [7:0] v,
                          output logic [31:0] rd, output int cyc);
      @(negedge clk);
      hc_req = 1'b1; hc_we = wr; hc_addr = 5'(ix << 2);
      hc_wdata = {24'hC3A5F0, v};
      cyc = 0;
      do begin
         @(negedge clk);
         cyc++;
      end while (!hc_ready && cyc < 100);
      rd = hc_rdata;
      hc_req = 1'b0; hc_we = 1'b0;
   endtask

   task automatic data_acc(input bit wr, input logic [7:0] b,
                           output logic [31:0] rd, output int cyc,
                           output int low, output int hcnt, output int bad);
      @(negedge clk);
      hc_req = 1'b1; hc_we = wr; hc_addr = 5'(IX_DATA << 2);
      hc_wdata = {24'h7E81C3, b};
      cyc = 0; low = 0; hcnt = 0; bad = 0;
      do begin
         @(negedge clk);
         cyc++;
         if (wr ? !fl_we_n : !fl_re_n) low++;
         else if (low > 0 && !hc_ready) hcnt++;
         if (wr && !fl_re_n) bad++;
         if (!wr && (!fl_we_n || fl_dq_oe)) bad++;
         if (fl_dq_oe && fl_dq_o != b) bad++;
         if (!fl_we_n && !fl_dq_oe) bad++;
      end while (!hc_ready && cyc < 100);
      rd = hc_rdata;
      hc_req = 1'b0; hc_we = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual 200000 cycles expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int cyc, low, hcnt, bad;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the pins
      chk(fl_ce_n == 4'hF && fl_we_n && fl_re_n && !fl_cle && !fl_ale &&
          !fl_dq_oe && !hc_ready, "R1 pins", {fl_ce_n, fl_we_n, fl_re_n},
          {4'hF, 2'b11});
      reg_acc(0, IX_MODE, 8'h00, rd, cyc);
      chk(rd == 32'h0, "R1 mode", rd, 32'h0);
      reg_acc(0, IX_TIME, 8'h00, rd, cyc);
      chk(rd == 32'h11, "R1 timing", rd, 32'h11);
      // R11 register latency
      chk(cyc == 1, "R11 reg latency", cyc, 1);
      reg_acc(0, IX_ISTAT, 8'h00, rd, cyc);
      chk(rd == 32'h0, "R11 istat", rd, 0);
      reg_acc(0, IX_IMASK, 8'h00, rd, cyc);
      chk(rd == 32'h0, "R11 imask", rd, 0);

      // R2 R3 sweep of chip select, CE, CLE, ALE
      for (int m = 0; m < 32; m++) begin
         logic [7:0] mv;
         logic [3:0] exp_ce;
         mv = {3'b000, m[4], m[3:2], m[1], m[0]};
         exp_ce = m[4] ? ~(4'b0001 << m[3:2]) : 4'hF;
         reg_acc(1, IX_MODE, mv, rd, cyc);
         chk(fl_ce_n == exp_ce, "R2 ce_n", fl_ce_n, exp_ce);
         chk(fl_cle == mv[0] && fl_ale == mv[1], "R3 cle/ale",
             {fl_ale, fl_cle}, mv[1:0]);
         reg_acc(0, IX_MODE, 8'h00, rd, cyc);
         chk(rd == 32'(mv), "R2 mode readback", rd, 32'(mv));
      end

      // R7 write with write mode clear
      reg_acc(1, IX_MODE, 8'h10, rd, cyc);
      data_acc(1, 8'h96, rd, cyc, low, hcnt, bad);
      chk(low == 0 && bad == 0 && !fl_dq_oe, "R7 no strobe", low, 0);
      chk(cyc == 1, "R7 latency", cyc, 1);

      // R4 R5 R8 full timing sweep on writes
      reg_acc(1, IX_MODE, 8'h90, rd, cyc);
      for (int t = 0; t < 256; t++) begin
         int es, eh;
         logic [7:0] b;
         es = (t % 16 == 0) ? 1 : t % 16;
         eh = (t / 16 == 0) ? 1 : t / 16;
         b  = 8'(t) ^ 8'h5A;
         reg_acc(1, IX_TIME, 8'(t), rd, cyc);
         reg_acc(0, IX_TIME, 8'h00, rd, cyc);
         chk(rd == 32'(eh * 16 + es), "R8 timing readback", rd, eh * 16 + es);
         data_acc(1, b, rd, cyc, low, hcnt, bad);
         chk(low == es + 1, "R4 we width", low, es + 1);
         chk(bad == 0, "R4 data/strobe", bad, 0);
         chk(hcnt == eh, "R5 hold", hcnt, eh);
         chk(cyc == es + eh + 2, "R5 latency", cyc, es + eh + 2);
      end

      // R6 read sweep
      for (int s = 0; s < 16; s++) begin
         int es, eh;
         logic [7:0] b;
         es = (s == 0) ? 1 : s;
         eh = ((s ^ 3) == 0) ? 1 : (s ^ 3);
         b = 8'(s * 37 + 11);
         fl_dq_i = b;
         reg_acc(1, IX_TIME, 8'(((s ^ 3) << 4) | s), rd, cyc);
         data_acc(0, 8'h00, rd, cyc, low, hcnt, bad);
         chk(rd == 32'(b), "R6 read data", rd, 32'(b));
         chk(low == es + 1 && bad == 0, "R6 re width", low, es + 1);
         chk(hcnt == eh && cyc == es + eh + 2, "R6 hold/latency", cyc,
             es + eh + 2);
      end

      // R9 busy status
      fl_rb_n = 1'b0;
      repeat (4) @(negedge clk);
      reg_acc(0, IX_STAT, 8'h00, rd, cyc);
      chk(rd == 32'h80, "R9 busy", rd, 32'h80);
      fl_rb_n = 1'b1;
      repeat (4) @(negedge clk);
      reg_acc(0, IX_STAT, 8'h00, rd, cyc);
      chk(rd == 32'h0, "R9 ready", rd, 0);

      // R10 soft reset
      reg_acc(1, IX_MODE, 8'h97, rd, cyc);
      reg_acc(1, IX_TIME, 8'h55, rd, cyc);
      reg_acc(1, IX_RST, 8'h01, rd, cyc);
      data_acc(1, 8'h3C, rd, cyc, low, hcnt, bad);
      chk(cyc == RSTC && low == 0, "R10 data stall", cyc, RSTC);
      reg_acc(0, IX_RST, 8'h00, rd, cyc);
      chk(rd == 32'h0, "R10 bit cleared", rd, 0);
      reg_acc(0, IX_MODE, 8'h00, rd, cyc);
      chk(rd == 32'h0 && fl_ce_n == 4'hF && !fl_cle, "R10 mode", rd, 0);
      reg_acc(0, IX_TIME, 8'h00, rd, cyc);
      chk(rd == 32'h11, "R10 timing", rd, 32'h11);
      reg_acc(1, IX_RST, 8'h01, rd, cyc);
      reg_acc(0, IX_RST, 8'h00, rd, cyc);
      chk(rd == 32'h1, "R10 bit pending", rd, 1);
      repeat (RSTC + 2) @(negedge clk);
      reg_acc(1, IX_MODE, 8'h10, rd, cyc);
      reg_acc(1, IX_RST, 8'h00, rd, cyc);
      reg_acc(0, IX_MODE, 8'h00, rd, cyc);
      chk(rd == 32'h10, "R10 zero write ignored", rd, 32'h10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule